// File: doc/BRIEF.md
# Incrementing-Byte SPI Master

This block is a self-running serial master. It has no host data port. After reset it sends frames on its own, one after another, and each frame carries one byte. The first byte is zero, and every later byte is one more than the byte before it. The count wraps from 255 back to 0.

The block drives three lines toward a single slave: a serial clock, a data line and an active-low select. The serial clock idles low. Data changes while the clock is low, so a slave that samples on the rising clock edge sees stable bits. Bits go out most-significant first. A divide parameter sets how many system clocks each half of a serial clock period lasts. A gap parameter sets how many half periods the select stays high between frames.

The reset input is active low and asynchronous when it asserts. It must be released synchronously to `clk`.

Top module: `spi_incr_tx`

## Requirements
- R1: While reset is asserted, and right after it is released, `cs_n` is 1 and `sclk` and `mosi` are 0. The first frame after reset carries 0x00.
- R2: `sclk` is 0 whenever `cs_n` is 1. Every level of `sclk`, and every interval between output changes, lasts a whole multiple of HALF_DIV system clocks.
- R3: Each frame, from a fall of `cs_n` to its next rise, holds exactly eight rising edges of `sclk`.
- R4: `mosi` carries the frame byte most-significant bit first. Bit 7 is valid at the first rising edge and bit 0 at the eighth. `mosi` never changes at a rising edge of `sclk`.
- R5: `cs_n` falls one half period before the first rising edge of `sclk`. It rises two half periods after the eighth rising edge, which is one half period after the last falling edge.
- R6: Between frames, and after reset, `cs_n` stays high for GAP_HALVES half periods (at least 4, which is two serial clock periods), and `mosi` is 0 during that time.
- R7: Each frame's byte is the previous frame's byte plus one, modulo 256. After 0xFF the next byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data toward the slave, MSB first |
| cs_n | output | 1 | Active-low slave select, low for one byte per frame |

## Verification
A wrong internal state appears on the serial lines within one half period. A slip in the half-period divider moves every later edge. A bit index that is off shifts the bit pattern or the count of rising edges in that same frame. A byte counter that misses an increment or a wrap shows up in the data of the very next frame. For these reasons the bench predicts all three outputs for every system clock from the elapsed time since reset. It runs past 256 frames so that the wrap is seen, and it asserts reset in the middle of a frame to check that the sequence restarts.

// File: rtl/spi_incr_pkg.sv
package spi_incr_pkg;
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/spi_incr_tick.sv
module spi_incr_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap_chk
      a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/spi_incr_ctr.sv
module spi_incr_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (inc) val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;

  a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc) |-> value == W'($past(value) + 1'b1));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inc) |-> $stable(value));
endmodule

// File: rtl/spi_incr_seq.sv
module spi_incr_seq
  import spi_incr_pkg::*;
#(
  parameter int W          = 8,
  parameter int GAP_HALVES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] tx_byte,
  output logic         frame_done,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi
);
  localparam int IW = $clog2(W);
  localparam int GW = $clog2(GAP_HALVES);
  localparam logic [IW-1:0] TOP_BIT = IW'(W - 1);
  localparam logic [GW-1:0] GAP_END = GW'(GAP_HALVES - 1);

  tx_state_t     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, idx_dn;
  logic [GW-1:0] gap_q, gap_d;
  logic          cs_q, cs_d, sck_q, sck_d, dat_q, dat_d;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    gap_d      = gap_q;
    cs_d       = cs_q;
    sck_d      = sck_q;
    dat_d      = dat_q;
    frame_done = 1'b0;
    idx_dn     = idx_q - 1'b1;
    if (tick) begin
      unique case (st_q)
        ST_GAP: begin
          if (gap_q == GAP_END) begin
            st_d  = ST_SHIFT;
            cs_d  = 1'b0;
            idx_d = TOP_BIT;
            dat_d = tx_byte[TOP_BIT];
          end else begin
            gap_d = gap_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!sck_q) begin
            sck_d = 1'b1;
          end else begin
            sck_d = 1'b0;
            if (idx_q == '0) begin
              st_d = ST_TAIL;
            end else begin
              idx_d = idx_dn;
              dat_d = tx_byte[idx_dn];
            end
          end
        end
        ST_TAIL: begin
          st_d       = ST_GAP;
          cs_d       = 1'b1;
          dat_d      = 1'b0;
          gap_d      = '0;
          frame_done = 1'b1;
        end
        default: st_d = ST_GAP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_GAP;
      idx_q <= '0;
      gap_q <= '0;
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      gap_q <= gap_d;
      cs_q  <= cs_d;
      sck_q <= sck_d;
      dat_q <= dat_d;
    end
  end

  assign cs_n = cs_q;
  assign sclk = sck_q;
  assign mosi = dat_q;

  a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  a_r2_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r6_mosi_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  a_r5_select_fall_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk && $past(!sclk));
  a_r5_select_rise_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(!sclk));
  a_r3_done_once_per_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !cs_n);
endmodule

// File: rtl/spi_incr_tx.sv
module spi_incr_tx #(
  parameter int HALF_DIV   = 4,
  parameter int GAP_HALVES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic mosi,
  output logic cs_n
);
  localparam int BYTE_W = 8;

  logic              tick;
  logic              frame_done;
  logic [BYTE_W-1:0] cur_byte;

  initial begin
    a_r6_gap_min: assert (GAP_HALVES >= 4);
    a_r2_div_min: assert (HALF_DIV >= 1);
  end

  spi_incr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  spi_incr_ctr #(.W(BYTE_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_done),
    .value (cur_byte)
  );

  spi_incr_seq #(.W(BYTE_W), .GAP_HALVES(GAP_HALVES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .tx_byte    (cur_byte),
    .frame_done (frame_done),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .mosi       (mosi)
  );
endmodule

// File: tb/tb_spi_incr_tx.sv
`timescale 1ns/1ps
module tb_spi_incr_tx;
  localparam int DIV = 2;
  localparam int GAP = 4;
  localparam int SEGS = GAP + 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk, mosi, cs_n;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  spi_incr_tx #(.HALF_DIV(DIV), .GAP_HALVES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  // Expected line levels j system clocks after reset release.
  task automatic expect_at(input int j, output logic e_cs, output logic e_sck,
                           output logic e_dat, output int bytev, output int pos);
    int seg, k;
    seg   = j / DIV;
    pos   = seg % SEGS;
    bytev = (seg / SEGS) % 256;
    if (pos < GAP) begin
      e_cs = 1; e_sck = 0; e_dat = 0;
    end else begin
      k = pos - GAP;
      e_cs = 0;
      if (k < 16) begin
        e_sck = k[0];
        e_dat = bytev[7 - k/2];
      end else begin
        e_sck = 0;
        e_dat = bytev[0];
      end
    end
  endtask

  task automatic compare(input int j);
    logic ec, es, ed;
    int b, p;
    expect_at(j, ec, es, ed, b, p);
    checks++;
    if (cs_n !== ec) begin
      fails++;
      $display("FAIL %s cs_n t=%0d actual=%b expected=%b", (p < GAP) ? "R6" : "R5", j, cs_n, ec);
    end
    if (sclk !== es) begin
      fails++;
      $display("FAIL R2/R3 sclk t=%0d actual=%b expected=%b", j, sclk, es);
    end
    if (mosi !== ed) begin
      fails++;
      $display("FAIL %s mosi t=%0d byte=%0d actual=%b expected=%b",
               (b == 0) ? "R4" : "R7", j, b, mosi, ed);
    end
  endtask

  task automatic reset_check();
    checks++;
    if (cs_n !== 1'b1 || sclk !== 1'b0 || mosi !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state actual=%b%b%b expected=100", cs_n, sclk, mosi);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_check();                        // R1 during reset
    rst_n = 1'b1;
    compare(0);                           // R1 right after release
    // Run past 257 frames so the 0xFF -> 0x00 wrap is seen (R7).
    for (int j = 1; j <= 257 * SEGS * DIV + 5; j++) begin
      @(negedge clk);
      compare(j);
    end
    // Reset in the middle of a frame, then the sequence restarts from byte 0 (R1).
    repeat (GAP * DIV + 7) @(negedge clk);
    rst_n = 1'b0;
    #3;
    reset_check();                        // R1 asynchronous assertion
    @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    compare(0);
    for (int j = 1; j <= 3 * SEGS * DIV; j++) begin
      @(negedge clk);
      compare(j);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule